// File: doc/BRIEF.md
# Cache Epoch Tracking Table

This block sits beside a cache controller and keeps a small record for every block the cache currently holds permission on. When the controller grants a block read-only (shared) or read-write (exclusive) permission, the table opens an epoch for it. The epoch records its kind, the logical time at which it began, whether the block data has arrived, and a 16-bit hash of that data. While the epoch is open, every load and store the cache performs is checked against it. An access that has no open epoch, or that is not allowed by it, raises an error flag.

When the controller gives permission up, the table closes the epoch and sends a report toward the block's home memory node. The report carries the recorded entry together with the end time and a hash of the data as it stands at the end. The home node can then check that epochs do not overlap and that data moves correctly from one epoch to the next. The table is direct-mapped on the low address bits, with 32 entries by default. The hash is the XOR of the block's 16-bit words. The report leaves on a valid/ready stream holding a single register. While that register waits to be taken, the table raises `busy` and does not accept another epoch end.

Top module: `epoch_tracker`

## Requirements
- R1: After reset no entry is open, `rpt_vld`, `busy` and `err` are low, and an access to any address raises `err` one cycle later.
- R2: A load (`acc_store`=0) to a block with an open epoch of either kind, whose data has arrived, leaves `err` low in the next cycle.
- R3: A store (`acc_store`=1) is accepted only in an exclusive epoch (`start_excl`=1). A store in a shared epoch raises `err` in the next cycle.
- R4: An access to an address whose index holds no open epoch, or whose tag (address bits above the low 5) differs from the open entry, raises `err` in the next cycle.
- R5: An epoch opens with its data-ready flag clear, and an access in that state raises `err`. A `fill` to the open block sets the flag and records the start hash, which is the XOR of the 16-bit words of `fill_data`.
- R6: An accepted epoch end on an open block closes the entry and presents a report in the next cycle: `rpt_addr`, the epoch kind, the data-ready flag, the start time and start hash, `end_time`, and the XOR-fold of `end_data`. Later accesses to that block raise `err`. `rpt_vld` falls after a cycle with `rpt_rdy` high unless a new report is loaded.
- R7: An epoch end for a block with no open epoch raises `err` in the next cycle and produces no report.
- R8: While `rpt_vld` is high and `rpt_rdy` is low, `busy` is high and the report is held unchanged. An epoch end offered in that state has no effect: it produces no report, the entry stays open, and no error is raised.
- R9: An access and an epoch end for the same block in the same cycle are both judged against the entry as it stood before that cycle, so the access is accepted and the report is produced.
- R10: Opening an epoch replaces whatever entry its index holds. An older block that mapped to the same index then fails its accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | 1 | Epoch start event |
| start_addr | input | 12 | Block address of the starting epoch |
| start_excl | input | 1 | 1 for an exclusive epoch, 0 for shared |
| start_time | input | 16 | Logical time at the start |
| fill_vld | input | 1 | Block data arrived |
| fill_addr | input | 12 | Block address of the arriving data |
| fill_data | input | 64 | Block data, four 16-bit words |
| end_vld | input | 1 | Epoch end event |
| end_addr | input | 12 | Block address of the ending epoch |
| end_time | input | 16 | Logical time at the end |
| end_data | input | 64 | Block data at the end |
| busy | output | 1 | Epoch end cannot be accepted this cycle |
| acc_vld | input | 1 | Access to check |
| acc_addr | input | 12 | Access block address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| rpt_vld | output | 1 | Report valid |
| rpt_rdy | input | 1 | Report taken |
| rpt_addr | output | 12 | Block address of the reported epoch |
| rpt_excl | output | 1 | Epoch kind |
| rpt_filled | output | 1 | Data-ready flag at the end |
| rpt_t0 | output | 16 | Start logical time |
| rpt_h0 | output | 16 | Start data hash |
| rpt_t1 | output | 16 | End logical time |
| rpt_h1 | output | 16 | End data hash |
| err | output | 1 | Error pulse, one cycle after the offending event |

## Verification
The riskiest coincidence is an access and the closing of its own epoch in the same cycle. If the access were judged against the already-closed entry, a legal store would be flagged. The bench drives a store and the epoch end for one exclusive block on the same edge. It expects `err` to stay low and the report to appear, and then expects the next access to fail. A second coincidence is an epoch end offered while a report is stalled. The bench checks that the held report is unchanged and that the block still accepts loads.

// File: rtl/epoch_tracker.sv
module epoch_tracker #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 5,
  parameter int TIME_W = 16,
  parameter int HASH_W = 16,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_vld,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic                    start_excl,
  input  logic [TIME_W-1:0]       start_time,
  input  logic                    fill_vld,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [WORDS*HASH_W-1:0] fill_data,
  input  logic                    end_vld,
  input  logic [ADDR_W-1:0]       end_addr,
  input  logic [TIME_W-1:0]       end_time,
  input  logic [WORDS*HASH_W-1:0] end_data,
  output logic                    busy,
  input  logic                    acc_vld,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic                    acc_store,
  output logic                    rpt_vld,
  input  logic                    rpt_rdy,
  output logic [ADDR_W-1:0]       rpt_addr,
  output logic                    rpt_excl,
  output logic                    rpt_filled,
  output logic [TIME_W-1:0]       rpt_t0,
  output logic [HASH_W-1:0]       rpt_h0,
  output logic [TIME_W-1:0]       rpt_t1,
  output logic [HASH_W-1:0]       rpt_h1,
  output logic                    err
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int BLK_W   = WORDS * HASH_W;

  function automatic logic [HASH_W-1:0] fold(input logic [BLK_W-1:0] d);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int k = 0; k < WORDS; k++) h = h ^ d[k*HASH_W +: HASH_W];
    return h;
  endfunction

  logic [ENTRIES-1:0] open_q, excl_q, fill_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TIME_W-1:0]  t0_q  [ENTRIES];
  logic [HASH_W-1:0]  h0_q  [ENTRIES];

  wire [IDX_W-1:0] s_idx = start_addr[IDX_W-1:0];
  wire [IDX_W-1:0] f_idx = fill_addr[IDX_W-1:0];
  wire [IDX_W-1:0] e_idx = end_addr[IDX_W-1:0];
  wire [IDX_W-1:0] a_idx = acc_addr[IDX_W-1:0];

  wire f_hit = open_q[f_idx] && tag_q[f_idx] == fill_addr[ADDR_W-1:IDX_W];
  wire e_hit = open_q[e_idx] && tag_q[e_idx] == end_addr[ADDR_W-1:IDX_W];
  wire a_hit = open_q[a_idx] && tag_q[a_idx] == acc_addr[ADDR_W-1:IDX_W];

  wire a_ok  = a_hit && fill_q[a_idx] && (!acc_store || excl_q[a_idx]);
  wire a_bad = acc_vld && !a_ok;

  assign busy = rpt_vld && !rpt_rdy;
  wire e_take = end_vld && !busy;
  wire e_ok   = e_take && e_hit;
  wire e_bad  = e_take && !e_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= '0;
      excl_q  <= '0;
      fill_q  <= '0;
      rpt_vld <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= a_bad || e_bad;
      if (rpt_vld && rpt_rdy) rpt_vld <= 1'b0;
      if (e_ok) begin
        rpt_vld       <= 1'b1;
        rpt_addr      <= end_addr;
        rpt_excl      <= excl_q[e_idx];
        rpt_filled    <= fill_q[e_idx];
        rpt_t0        <= t0_q[e_idx];
        rpt_h0        <= h0_q[e_idx];
        rpt_t1        <= end_time;
        rpt_h1        <= fold(end_data);
        open_q[e_idx] <= 1'b0;
      end
      if (fill_vld && f_hit) begin
        fill_q[f_idx] <= 1'b1;
        h0_q[f_idx]   <= fold(fill_data);
      end
      if (start_vld) begin
        open_q[s_idx] <= 1'b1;
        fill_q[s_idx] <= 1'b0;
        excl_q[s_idx] <= start_excl;
        tag_q[s_idx]  <= start_addr[ADDR_W-1:IDX_W];
        t0_q[s_idx]   <= start_time;
      end
    end
  end
endmodule

module epoch_tracker_chk #(
  parameter int ADDR_W = 12,
  parameter int TIME_W = 16,
  parameter int HASH_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              end_vld,
  input logic [TIME_W-1:0] end_time,
  input logic              busy,
  input logic              rpt_vld,
  input logic              rpt_rdy,
  input logic [ADDR_W-1:0] rpt_addr,
  input logic [TIME_W-1:0] rpt_t1,
  input logic [HASH_W-1:0] rpt_h1,
  input logic              err
);
  // R8
  rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld && !rpt_rdy |=> rpt_vld && $stable(rpt_addr) && $stable(rpt_t1) && $stable(rpt_h1));
  // R8
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rpt_vld);
  // R6
  rpt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_vld) |-> $past(end_vld) && rpt_t1 == $past(end_time));
  // R6
  rpt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld && rpt_rdy && !end_vld |=> !rpt_vld);
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(acc_vld) || $past(end_vld));
endmodule

bind epoch_tracker epoch_tracker_chk #(.ADDR_W(ADDR_W), .TIME_W(TIME_W), .HASH_W(HASH_W)) u_chk (.*);

// File: tb/epoch_tracker_bench.sv
module epoch_tracker_bench;
  logic        clk = 0, rst_n = 0;
  logic        start_vld = 0, start_excl = 0;
  logic [11:0] start_addr = 0, fill_addr = 0, end_addr = 0, acc_addr = 0;
  logic [15:0] start_time = 0, end_time = 0;
  logic        fill_vld = 0, end_vld = 0, acc_vld = 0, acc_store = 0, rpt_rdy = 0;
  logic [63:0] fill_data = 0, end_data = 0;
  logic        busy, rpt_vld, rpt_excl, rpt_filled, err;
  logic [11:0] rpt_addr;
  logic [15:0] rpt_t0, rpt_h0, rpt_t1, rpt_h1;
  int checks = 0, fails = 0;
  bit done = 0;

  epoch_tracker u_epoch_tracker (.*);

  always #4 clk = ~clk;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] blk(input int i, input logic [15:0] salt);
    logic [63:0] d;
    for (int k = 0; k < 4; k++) d[k*16 +: 16] = 16'(i * 16'h0135 + k * 16'h2461) ^ salt;
    return d;
  endfunction

  function automatic logic [15:0] xh(input logic [63:0] d);
    return d[15:0] ^ d[31:16] ^ d[47:32] ^ d[63:48];
  endfunction

  task automatic acc(input logic [11:0] a, input logic st);
    acc_vld = 1; acc_addr = a; acc_store = st; tick; acc_vld = 0;
  endtask
  task automatic opn(input logic [11:0] a, input logic ex, input logic [15:0] t);
    start_vld = 1; start_addr = a; start_excl = ex; start_time = t; tick; start_vld = 0;
  endtask
  task automatic fil(input logic [11:0] a, input logic [63:0] d);
    fill_vld = 1; fill_addr = a; fill_data = d; tick; fill_vld = 0;
  endtask
  task automatic fin(input logic [11:0] a, input logic [15:0] t, input logic [63:0] d);
    end_vld = 1; end_addr = a; end_time = t; end_data = d; tick; end_vld = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    chk("R1 err", err, 0);
    chk("R1 rpt_vld", rpt_vld, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1; tick;
    acc(12'h000, 0); chk("R1 access after reset", err, 1);

    for (int i = 0; i < 32; i++) begin
      logic [11:0] a, b;
      logic ex;
      a = {7'(i + 3), 5'(i)};
      b = {7'(i + 40), 5'(i)};
      ex = i[0];
      acc(a, 0); chk("R4 no epoch", err, 1);
      opn(a, ex, 16'(i * 100 + 7));
      acc(a, 0); chk("R5 before data", err, 1);
      fil(a, blk(i, 16'h5a5a));
      acc(a, 0); chk("R2 load", err, 0);
      acc(a, 1); chk("R3 store", err, !ex);
      acc(b, 0); chk("R4 tag mismatch", err, 1);
      rpt_rdy = 0;
      fin(a, 16'(i * 100 + 900), blk(i, 16'hc3c3));
      chk("R6 err", err, 0);
      chk("R6 rpt_vld", rpt_vld, 1);
      chk("R6 addr", rpt_addr, a);
      chk("R6 kind", rpt_excl, ex);
      chk("R6 filled", rpt_filled, 1);
      chk("R6 t0", rpt_t0, 16'(i * 100 + 7));
      chk("R5 start hash", rpt_h0, xh(blk(i, 16'h5a5a)));
      chk("R6 t1", rpt_t1, 16'(i * 100 + 900));
      chk("R6 end hash", rpt_h1, xh(blk(i, 16'hc3c3)));
      chk("R8 busy", busy, 1);
      tick;
      chk("R8 held", rpt_t1, 16'(i * 100 + 900));
      acc(a, 0); chk("R6 closed", err, 1);
      rpt_rdy = 1; tick;
      chk("R6 drop", rpt_vld, 0);
      rpt_rdy = 0;
    end

    fin(12'h020, 16'h1234, 64'h0);
    chk("R7 err", err, 1);
    chk("R7 no report", rpt_vld, 0);

    opn(12'h040, 1, 16'h0010); fil(12'h040, blk(1, 16'h1111));
    opn(12'h041, 0, 16'h0020); fil(12'h041, blk(2, 16'h2222));
    fin(12'h040, 16'h0100, blk(3, 16'h0));
    chk("R8 first report", rpt_t1, 16'h0100);
    fin(12'h041, 16'h0200, blk(4, 16'h0));
    chk("R8 ignored end t1", rpt_t1, 16'h0100);
    chk("R8 ignored end addr", rpt_addr, 12'h040);
    chk("R8 ignored end err", err, 0);
    acc(12'h041, 0); chk("R8 still open", err, 0);
    rpt_rdy = 1; tick; rpt_rdy = 0;
    fin(12'h041, 16'h0200, blk(4, 16'h0));
    chk("R8 later report", rpt_t1, 16'h0200);
    chk("R8 later kind", rpt_excl, 0);
    rpt_rdy = 1; tick;

    opn(12'h062, 1, 16'h0300); fil(12'h062, blk(5, 16'h3333));
    acc_vld = 1; acc_addr = 12'h062; acc_store = 1;
    end_vld = 1; end_addr = 12'h062; end_time = 16'h0400; end_data = blk(6, 16'h0);
    tick; acc_vld = 0; end_vld = 0;
    chk("R9 access ok", err, 0);
    chk("R9 report", rpt_vld, 1);
    chk("R9 report t1", rpt_t1, 16'h0400);
    acc(12'h062, 0); chk("R9 closed after", err, 1);
    rpt_rdy = 0;

    opn(12'h083, 1, 16'h0500); fil(12'h083, blk(7, 16'h4444));
    opn(12'h0a3, 0, 16'h0600);
    acc(12'h083, 0); chk("R10 replaced", err, 1);
    acc(12'h0a3, 0); chk("R10 new not ready", err, 1);
    fil(12'h0a3, blk(8, 16'h5555));
    acc(12'h0a3, 0); chk("R10 new load", err, 0);
    acc(12'h0a3, 1); chk("R10 new shared store", err, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule